// File: doc/BRIEF.md
# Flash self-programming command controller

This block sits between a small CPU core and the on-chip flash and protection-byte storage. Software writes a six-bit command code. A legal code arms a short window during which the next store-program instruction (or, for a protection readback, the next load-program instruction) does something special: fill one word of the temporary page buffer, clear that buffer, start a page erase or page write, or return the lock or fuse bytes in place of flash contents.

Each window runs on its own saturating down-counter. When a window lapses or its instruction arrives, the block clears the command bits by itself. Once an erase or write starts, the command stays pending and the block reports busy until the flash controller signals completion. While an EEPROM write is in progress, command writes and protection readbacks are refused.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `cmd_state` is 0, `busy` is 0, and the strobes `buf_fill`, `buf_clr`, `erase_start`, `write_start` and `rb_prot` are all 0.
- R2: A `cmd_wr` with one of the codes 6'b000001 (fill), 6'b000011 (erase), 6'b000101 (write), 6'b001001 (readback), 6'b010001 (buffer clear) or 6'b100001 (auxiliary) is loaded into `cmd_state` on the next cycle. Bit 0 is enable, bit 1 erase, bit 2 write, bit 3 readback, bit 4 buffer clear and bit 5 auxiliary. Any other code leaves `cmd_state` and the windows unchanged.
- R3: With the fill code loaded, a `store_exec` in any of the 4 cycles after the write raises `buf_fill` in that cycle, with `buf_addr` equal to `ptr_addr` with bit 0 forced to 0 and `buf_data` equal to `pair_data`. `cmd_state` is 0 on the next cycle. A `store_exec` with no armed command raises no strobe.
- R4: If no store-program instruction arrives within 4 cycles of a command write, `cmd_state` reads 0 in the 5th cycle.
- R5: With the erase or write code loaded, a `store_exec` in the window pulses `erase_start` or `write_start` for one cycle. From the next cycle, `busy` is 1 and `cmd_state` holds its value until `op_done`. On the cycle after `op_done`, both read 0.
- R6: While `busy` is 1, any `cmd_wr` is ignored.
- R7: With the readback code loaded, a `load_exec` in any of the 3 cycles after the write returns protection data with `rb_prot` = 1. Address 0x0000 returns `fuse_lo`, address 0x0001 returns {6'b111111, `lock_bits`}, and address 0x0003 returns `fuse_hi`. Any other load returns `flash_rdata` with `rb_prot` = 0.
- R8: A readback command clears (`cmd_state` = 0) on the cycle after its load. If no load arrives, it clears in the 4th cycle after the write. A `store_exec` during a readback window does not consume it.
- R9: While `ee_busy` is 1, `cmd_wr` is ignored and `load_exec` returns `flash_rdata` with `rb_prot` = 0.
- R10: With the buffer-clear code loaded, a store in the window pulses `buf_clr`. With the auxiliary code loaded, a store raises no strobe. In both cases `cmd_state` is 0 on the next cycle.
- R11: A legal `cmd_wr` while a window is armed (not busy) replaces the command and restarts its windows. This holds even when a store or load arrives in the same cycle, and in that case the store or load raises no special strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 6 | Command code written |
| store_exec | input | 1 | Store-program instruction executes this cycle |
| load_exec | input | 1 | Load-program instruction executes this cycle |
| ptr_addr | input | 16 | Pointer register address |
| pair_data | input | 16 | Register-pair word for a buffer fill |
| ee_busy | input | 1 | EEPROM write in progress |
| op_done | input | 1 | Flash controller finished erase or write |
| lock_bits | input | 2 | Lock bits |
| fuse_lo | input | 8 | Fuse low byte |
| fuse_hi | input | 8 | Fuse high byte |
| flash_rdata | input | 8 | Flash byte for a normal load |
| cmd_state | output | 6 | Current command bits |
| busy | output | 1 | Erase or write pending |
| buf_fill | output | 1 | Page-buffer word write strobe |
| buf_clr | output | 1 | Page-buffer clear strobe |
| buf_addr | output | 16 | Page-buffer word address (bit 0 zero) |
| buf_data | output | 16 | Page-buffer word data |
| erase_start | output | 1 | Page erase start strobe |
| write_start | output | 1 | Page write start strobe |
| rb_prot | output | 1 | Load returns protection data |
| rb_data | output | 8 | Load result byte |

## Verification
Two functions can fall in one cycle: a new command write and the end of the current window, either because its store or load arrives or because the counter runs out. The same applies to `op_done` and a command write while busy. The bench provokes these collisions with directed sequences that put a write on the exact cycle of a store, a load, or the last window cycle, and with random stimulus that keeps writes, stores and loads dense. The expected outcome is that the new write wins and that a write arriving together with `op_done` is still dropped. A bench reference model judges every output in every cycle against that rule.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CODE_W  = 6;
  localparam int EN_BIT  = 0;
  localparam int ERS_BIT = 1;
  localparam int WRT_BIT = 2;
  localparam int RB_BIT  = 3;
  localparam int CLR_BIT = 4;
  localparam int AUX_BIT = 5;
  localparam int N_CODES = 6;

  localparam logic [CODE_W-1:0] CODE_FILL = 6'b000001;

  // legal codes: enable alone or enable with exactly one function bit
  localparam logic [CODE_W-1:0] LEGAL_CODES [N_CODES] = '{
    6'b000001, 6'b000011, 6'b000101, 6'b001001, 6'b010001, 6'b100001
  };
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic              legal
);
  logic [N_CODES-1:0] hit;

  for (genvar i = 0; i < N_CODES; i++) begin : g_match
    assign hit[i] = (code == LEGAL_CODES[i]);
  end

  assign legal = |hit;
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter  int LIMIT = 4,
  localparam int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  output logic active,
  output logic expire
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = W'(LIMIT);
    else if (clr)            cnt_d = '0;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
  assign expire = (cnt_q == W'(1)) && !load && !clr;

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(LIMIT));
  p_expire_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !active);
endmodule

// File: rtl/rb_mux.sv
module rb_mux #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          hit,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    lock_bits,
  input  logic [BW-1:0] fuse_lo,
  input  logic [BW-1:0] fuse_hi,
  input  logic [BW-1:0] flash_rdata,
  output logic          prot,
  output logic [BW-1:0] data
);
  always_comb begin
    prot = 1'b0;
    data = flash_rdata;
    if (hit) begin
      case (addr)
        AW'(0): begin prot = 1'b1; data = fuse_lo; end
        AW'(1): begin prot = 1'b1; data = {{(BW-2){1'b1}}, lock_bits}; end
        AW'(3): begin prot = 1'b1; data = fuse_hi; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int BW     = 8,
  parameter int ST_WIN = 4,
  parameter int LD_WIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              store_exec,
  input  logic              load_exec,
  input  logic [AW-1:0]     ptr_addr,
  input  logic [DW-1:0]     pair_data,
  input  logic              ee_busy,
  input  logic              op_done,
  input  logic [1:0]        lock_bits,
  input  logic [BW-1:0]     fuse_lo,
  input  logic [BW-1:0]     fuse_hi,
  input  logic [BW-1:0]     flash_rdata,
  output logic [CODE_W-1:0] cmd_state,
  output logic              busy,
  output logic              buf_fill,
  output logic              buf_clr,
  output logic [AW-1:0]     buf_addr,
  output logic [DW-1:0]     buf_data,
  output logic              erase_start,
  output logic              write_start,
  output logic              rb_prot,
  output logic [BW-1:0]     rb_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [CODE_W-1:0] cmd_q, cmd_d;
  logic              pend_q, pend_d;
  logic              code_legal, wr_ok;
  logic              st_act, st_exp, ld_act, ld_exp;
  logic              store_hit, load_hit, start_op;

  cmd_decode u_dec (.code(cmd_code), .legal(code_legal));

  assign wr_ok     = cmd_wr && !ee_busy && !pend_q && code_legal;
  assign store_hit = store_exec && st_act && cmd_q[EN_BIT] && !pend_q
                     && !cmd_q[RB_BIT] && !wr_ok;
  assign load_hit  = load_exec && ld_act && cmd_q[RB_BIT] && cmd_q[EN_BIT]
                     && !ee_busy && !wr_ok;
  assign start_op  = cmd_q[ERS_BIT] || cmd_q[WRT_BIT];

  window_timer #(.LIMIT(ST_WIN)) u_st_win (
    .clk(clk), .rst_n(rst_i_n),
    .load(wr_ok),
    .clr(store_hit || load_hit || ld_exp),
    .active(st_act), .expire(st_exp)
  );

  window_timer #(.LIMIT(LD_WIN)) u_ld_win (
    .clk(clk), .rst_n(rst_i_n),
    .load(wr_ok && cmd_code[RB_BIT]),
    .clr(wr_ok || store_hit || load_hit),
    .active(ld_act), .expire(ld_exp)
  );

  // next state: new write > pending completion > consumption > expiry
  always_comb begin
    cmd_d  = cmd_q;
    pend_d = pend_q;
    if (wr_ok) begin
      cmd_d  = cmd_code;
      pend_d = 1'b0;
    end else if (pend_q) begin
      if (op_done) begin
        cmd_d  = '0;
        pend_d = 1'b0;
      end
    end else if (store_hit) begin
      if (start_op) pend_d = 1'b1;
      else          cmd_d  = '0;
    end else if (load_hit || st_exp || ld_exp) begin
      cmd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      pend_q <= pend_d;
    end
  end

  assign cmd_state   = cmd_q;
  assign busy        = pend_q;
  assign buf_fill    = store_hit && (cmd_q == CODE_FILL);
  assign buf_clr     = store_hit && cmd_q[CLR_BIT];
  assign erase_start = store_hit && cmd_q[ERS_BIT];
  assign write_start = store_hit && cmd_q[WRT_BIT];
  assign buf_addr    = {ptr_addr[AW-1:1], 1'b0};
  assign buf_data    = pair_data;

  rb_mux #(.AW(AW), .BW(BW)) u_rb (
    .hit(load_hit), .addr(ptr_addr), .lock_bits(lock_bits),
    .fuse_lo(fuse_lo), .fuse_hi(fuse_hi), .flash_rdata(flash_rdata),
    .prot(rb_prot), .data(rb_data)
  );

  p_busy_keeps_enable_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |-> cmd_state[EN_BIT]);
  p_busy_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && !op_done) |=> (cmd_state == $past(cmd_state)));
  p_done_releases_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && op_done) |=> (!busy && cmd_state == '0));
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({buf_fill, buf_clr, erase_start, write_start}));
  p_eeprom_blocks_rb_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    ee_busy |-> !rb_prot);
  p_fill_consumed_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (buf_fill && !cmd_wr) |=> (cmd_state == '0));
  p_rb_needs_cmd_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    rb_prot |-> (cmd_state[RB_BIT] && cmd_state[EN_BIT]));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr, store_exec, load_exec, ee_busy, op_done;
  logic [5:0]  cmd_code;
  logic [15:0] ptr_addr, pair_data;
  logic [1:0]  lock_bits;
  logic [7:0]  fuse_lo, fuse_hi, flash_rdata;
  logic [5:0]  cmd_state;
  logic        busy, buf_fill, buf_clr, erase_start, write_start, rb_prot;
  logic [15:0] buf_addr, buf_data;
  logic [7:0]  rb_data;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [5:0] m_cmd;
  int         m_st, m_ld;
  logic       m_pend;

  always #5 clk = ~clk;

  flash_cmd_ctrl u_flash_cmd_ctrl (.*);

  function automatic logic is_legal(input logic [5:0] c);
    return c inside {6'b000001, 6'b000011, 6'b000101,
                     6'b001001, 6'b010001, 6'b100001};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one cycle: drive after negedge, compare before posedge, advance model
  task automatic step(input string tag, input logic wr, input logic [5:0] code,
                      input logic st, input logic ld, input logic [15:0] addr,
                      input logic ee, input logic done);
    logic wr_ok, sh, lh, ld_exp, st_exp, e_prot;
    logic [7:0] e_rb;
    cmd_wr = wr; cmd_code = code; store_exec = st; load_exec = ld;
    ptr_addr = addr; ee_busy = ee; op_done = done;
    #4;
    wr_ok  = wr && !ee && !m_pend && is_legal(code);
    sh     = st && m_st != 0 && m_cmd[0] && !m_pend && !m_cmd[3] && !wr_ok;
    lh     = ld && m_ld != 0 && m_cmd[3] && m_cmd[0] && !ee && !wr_ok;
    e_prot = lh && (addr == 16'h0000 || addr == 16'h0001 || addr == 16'h0003);
    e_rb   = flash_rdata;
    if (e_prot)
      e_rb = (addr == 16'h0000) ? fuse_lo :
             (addr == 16'h0001) ? {6'b111111, lock_bits} : fuse_hi;
    chk({tag, " cmd_state"}, 16'(cmd_state), 16'(m_cmd));
    chk({tag, " busy"}, 16'(busy), 16'(m_pend));
    chk({tag, " buf_fill"}, 16'(buf_fill), 16'(sh && m_cmd == 6'b000001));
    chk({tag, " buf_clr"}, 16'(buf_clr), 16'(sh && m_cmd[4]));
    chk({tag, " erase_start"}, 16'(erase_start), 16'(sh && m_cmd[1]));
    chk({tag, " write_start"}, 16'(write_start), 16'(sh && m_cmd[2]));
    chk({tag, " rb_prot"}, 16'(rb_prot), 16'(e_prot));
    chk({tag, " rb_data"}, 16'(rb_data), 16'(e_rb));
    if (sh && m_cmd == 6'b000001) begin
      chk({tag, " buf_addr"}, buf_addr, {addr[15:1], 1'b0});
      chk({tag, " buf_data"}, buf_data, pair_data);
    end
    ld_exp = (m_ld == 1) && !wr_ok && !sh && !lh;
    st_exp = (m_st == 1) && !wr_ok && !(sh || lh || ld_exp);
    @(posedge clk);
    if (wr_ok) begin
      m_cmd = code; m_pend = 1'b0;
    end else if (m_pend) begin
      if (done) begin m_cmd = '0; m_pend = 1'b0; end
    end else if (sh) begin
      if (m_cmd[1] || m_cmd[2]) m_pend = 1'b1;
      else m_cmd = '0;
    end else if (lh || st_exp || ld_exp) m_cmd = '0;
    if (wr_ok)                  m_st = 4;
    else if (sh || lh || ld_exp) m_st = 0;
    else if (m_st != 0)         m_st--;
    if (wr_ok && code[3])       m_ld = 3;
    else if (wr_ok || sh || lh) m_ld = 0;
    else if (m_ld != 0)         m_ld--;
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 6'd0, 0, 0, 16'h0100, 0, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_cmd = '0; m_st = 0; m_ld = 0; m_pend = 1'b0;
    cmd_wr = 0; cmd_code = 0; store_exec = 0; load_exec = 0; ee_busy = 0; op_done = 0;
    ptr_addr = 0; pair_data = 16'hBEEF; lock_bits = 2'b10;
    fuse_lo = 8'h62; fuse_hi = 8'hD9; flash_rdata = 8'h3C;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    step("R1 reset", 0, 0, 0, 0, 16'h0, 0, 0);
    chk("R1 cmd_state", 16'(cmd_state), 16'h0);

    // R3 fill at last window cycle, LSB of pointer dropped
    step("R2 write fill", 1, 6'b000001, 0, 0, 0, 0, 0);
    idle("R3 wait", 3);
    step("R3 fill", 0, 0, 1, 0, 16'h1235, 0, 0);
    step("R3 after fill", 0, 0, 1, 0, 16'h1235, 0, 0);
    chk("R3 cleared", 16'(cmd_state), 16'h0);

    // R4 expiry after four cycles
    step("R2 write fill", 1, 6'b000001, 0, 0, 0, 0, 0);
    idle("R4 wait", 4);
    chk("R4 expired", 16'(cmd_state), 16'h0);
    step("R3 late store", 0, 0, 1, 0, 16'h0040, 0, 0);

    // R5/R6 erase then pending
    step("R2 write erase", 1, 6'b000011, 0, 0, 0, 0, 0);
    step("R5 erase", 0, 0, 1, 0, 16'h0080, 0, 0);
    step("R6 write while busy", 1, 6'b000001, 0, 0, 0, 0, 0);
    idle("R5 pending", 6);
    chk("R5 busy held", 16'(busy), 16'h1);
    step("R6 write with done", 1, 6'b000101, 0, 0, 0, 0, 1);
    chk("R5 released", 16'(cmd_state), 16'h0);

    // R5 page write
    step("R2 write pagewr", 1, 6'b000101, 0, 0, 0, 0, 0);
    step("R5 pagewr", 0, 0, 1, 0, 16'h0100, 0, 0);
    step("R5 done", 0, 0, 0, 0, 0, 0, 1);
    idle("R5 idle", 1);

    // R7 readback per address, R8 store does not consume
    for (int a = 0; a < 5; a++) begin
      step("R2 write rb", 1, 6'b001001, 0, 0, 0, 0, 0);
      step("R8 store in rb", 0, 0, 1, 0, 0, 0, 0);
      step("R7 load", 0, 0, 0, 1, 16'(a), 0, 0);
      step("R8 after load", 0, 0, 0, 1, 16'(a), 0, 0);
    end
    // R8 readback expiry
    step("R2 write rb", 1, 6'b001001, 0, 0, 0, 0, 0);
    idle("R8 wait", 3);
    chk("R8 expired", 16'(cmd_state), 16'h0);

    // R2 illegal codes
    step("R2 illegal", 1, 6'b000111, 0, 0, 0, 0, 0);
    step("R2 illegal", 1, 6'b000000, 0, 0, 0, 0, 0);
    step("R2 write fill", 1, 6'b000001, 0, 0, 0, 0, 0);
    step("R2 illegal armed", 1, 6'b110001, 0, 0, 0, 0, 0);
    chk("R2 kept", 16'(cmd_state), 16'h1);
    idle("R4 drain", 4);

    // R9 EEPROM busy
    step("R9 write blocked", 1, 6'b000001, 0, 0, 0, 1, 0);
    step("R2 write rb", 1, 6'b001001, 0, 0, 0, 0, 0);
    step("R9 load blocked", 0, 0, 0, 1, 16'h0001, 1, 0);
    step("R7 load ok", 0, 0, 0, 1, 16'h0001, 0, 0);
    idle("R8 idle", 1);

    // R10 buffer clear and auxiliary
    step("R2 write clr", 1, 6'b010001, 0, 0, 0, 0, 0);
    step("R10 clr", 0, 0, 1, 0, 0, 0, 0);
    step("R2 write aux", 1, 6'b100001, 0, 0, 0, 0, 0);
    step("R10 aux", 0, 0, 1, 0, 0, 0, 0);
    idle("R10 idle", 1);
    chk("R10 cleared", 16'(cmd_state), 16'h0);

    // R11 collisions: write with store, write on last window cycle, write with load
    step("R2 write fill", 1, 6'b000001, 0, 0, 0, 0, 0);
    step("R11 write+store", 1, 6'b000011, 1, 0, 0, 0, 0);
    idle("R11 wait", 3);
    step("R11 write at expiry", 1, 6'b001001, 0, 0, 0, 0, 0);
    step("R11 write+load", 1, 6'b000001, 0, 1, 16'h0000, 0, 0);
    step("R11 fill", 0, 0, 1, 0, 16'h0222, 0, 0);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] c;
      logic       pick;
      pick = ($urandom % 4) != 0;
      c = pick ? (6'b000001 | (6'(1) << ($urandom % 6))) : 6'($urandom);
      pair_data   = 16'($urandom);
      lock_bits   = 2'($urandom);
      fuse_lo     = 8'($urandom);
      fuse_hi     = 8'($urandom);
      flash_rdata = 8'($urandom);
      step("R11 random", ($urandom % 5) == 0, c, ($urandom % 4) == 0,
           ($urandom % 4) == 0, 16'($urandom % 6), ($urandom % 10) == 0,
           ($urandom % 6) == 0);
    end
    finish_run();
  end
endmodule